// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns access requests from an 8-bit processor core into timed cycles on an external bus. One 8-bit port carries the low address byte first and the data byte after it. An address strobe rises once in every machine cycle, so it can also serve as a clock output for external logic. For each machine cycle the core offers one request on `req_op` together with an address and write data. The block captures the request on the clock edge where the address strobe rises. It then steps through four named states, and the state decides what the bus does in that part of the cycle.

Three kinds of access are supported. The first is a program fetch, which puts a 12-bit address on the bus, with the upper nibble on a separate four-bit port, and reads the instruction byte under a program-strobe pulse. The second is a data read or write, which puts an 8-bit address on the bus and moves the data with a read or a write strobe. The third is a static output write, which loads a latch that drives the bus whenever no external access is using it. A fetch only goes to the external bus when external access is forced, or when the address lies at or above the internal ROM size. A fetch from a lower address makes no bus cycle. A byte read from the bus is handed back to the core for one clock.

The state machine has four states: `ST_ADDR` (address strobe high, address driven), `ST_HOLD` (address held after the strobe falls), `ST_STROBE` (program, read or write strobe active) and `ST_TAIL` (strobes inactive, remainder of the cycle). Each transition fires at a fixed clock count within the cycle: `ST_ADDR`→`ST_HOLD` after `ALE_LEN` clocks, `ST_HOLD`→`ST_STROBE` after a further `HOLD_LEN`, `ST_STROBE`→`ST_TAIL` after `STB_LEN`, and `ST_TAIL`→`ST_ADDR` at the end of the `CYC_LEN`-clock cycle. The `ST_TAIL`→`ST_ADDR` transition is the capture point. After reset the machine sits in the last clock of `ST_TAIL`, so the first edge after reset starts a cycle. With the default timing, a cycle spans clocks 0..14. The address strobe is high in clocks 0..3, the address is held in clocks 4..5, the strobe is active in clocks 6..11 and the tail covers clocks 12..14.

Top module: `ext_bus_seq`

## Requirements
- R1: `ale` is high in clocks 0..3 of every 15-clock machine cycle and low in clocks 4..14, whatever the access. It is low while `rst_n` is low, and the first cycle begins on the first clock edge after reset is released.
- R2: The request inputs (`req_op`, `req_addr`, `req_wdata`, `ext_access`) are sampled only on the edge that begins a machine cycle. Changing them later in the cycle has no effect on that cycle.
- R3: An external fetch drives `req_addr[7:0]` on `db_out` with `db_oe` high in clocks 0..5. It drives `p2_addr = req_addr[11:8]` with `p2_oe` high for the whole cycle, pulls `psen_n` low in clocks 6..11 and releases `db_oe` in clocks 6..14.
- R4: A fetch goes external when `ext_access` is 1 or `req_addr` >= 1024. Otherwise it makes no strobe, no response and no `p2_oe`, and the bus behaves as in an idle cycle.
- R5: A data read drives `req_addr[7:0]` on the bus in clocks 0..5. It pulls `rd_n` low in clocks 6..11 with `db_oe` low from clock 6 on, and it leaves `p2_oe` low.
- R6: A data write drives `req_addr[7:0]` in clocks 0..5 and `req_wdata` in clocks 6..14 with `db_oe` high throughout. It pulls `wr_n` low in clocks 6..11.
- R7: For an external fetch or a data read, `db_in` is captured on the edge where the strobe rises. `rsp_valid` is then high in clock 12 only, with `rsp_data` equal to the captured byte.
- R8: A bus output request loads `req_wdata` into the static latch on the edge where `ale` rises. From that cycle on, every cycle without an external access drives the latch value with `db_oe` high. Before the first output request after reset, such cycles leave `db_oe` low.
- R9: At most one of `psen_n`, `rd_n` and `wr_n` is low at a time. `db_oe` is never high while `psen_n` or `rd_n` is low. No strobe is low while `ale` is high.
- R10: The `req_op` encoding is 0 idle, 1 fetch, 2 data read, 3 data write and 4 bus output. The values 5..7 act as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 3 | Request kind for the next machine cycle |
| req_addr | input | 12 | Program address, or data address in bits 7:0 |
| req_wdata | input | 8 | Write data or bus output data |
| ext_access | input | 1 | Forces every fetch onto the external bus |
| db_in | input | 8 | Value read from the bus pins |
| ale | output | 1 | Address strobe, once per machine cycle |
| psen_n | output | 1 | Active-low program read strobe |
| rd_n | output | 1 | Active-low data read strobe |
| wr_n | output | 1 | Active-low data write strobe |
| db_out | output | 8 | Value driven on the bus pins |
| db_oe | output | 1 | Bus output enable |
| p2_addr | output | 4 | Upper program address nibble |
| p2_oe | output | 1 | Enable for the upper nibble |
| rsp_valid | output | 1 | Read byte valid, one clock |
| rsp_data | output | 8 | Byte captured from the bus |

## Verification
The bound checker watches, on every clock, the 15-clock spacing between rising edges of `ale`. It also checks that the strobes are exclusive and never overlap `ale`, that the bus is released during program and read strobes, that write data stays stable while `wr_n` is low, and that every response directly follows a read-type strobe. The bench scenarios are needed for the cases the checker cannot judge. These are which address and data bytes appear in each clock, the internal/external decision at the 1024 boundary and under forced external access, the persistence of the static output latch across later idle cycles, and the fact that request changes after the capture edge are ignored.

// File: rtl/ext_bus_seq_pkg.sv
`timescale 1ns/1ps
package ext_bus_seq_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_FETCH = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_OUT   = 3'd4
    } req_op_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_FETCH,
        K_READ,
        K_WRITE
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_ADDR,
        ST_HOLD,
        ST_STROBE,
        ST_TAIL
    } bus_state_e;

endpackage

// File: rtl/bus_seq_phase.sv
`timescale 1ns/1ps
module bus_seq_phase #(
    parameter int CYC_LEN = 15,
    parameter int PH_W    = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] ph,
    output logic            ph_last
);
    localparam logic [PH_W-1:0] PH_MAX = PH_W'(CYC_LEN - 1);

    assign ph_last = (ph == PH_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n)       ph <= PH_MAX;
        else if (ph_last) ph <= '0;
        else              ph <= ph + 1'b1;
    end
endmodule

// File: rtl/bus_seq_outlatch.sv
`timescale 1ns/1ps
module bus_seq_outlatch #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DB_W-1:0] din,
    output logic            valid,
    output logic [DB_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            q     <= '0;
        end else if (load) begin
            valid <= 1'b1;
            q     <= din;
        end
    end
endmodule

// File: rtl/bus_seq_rdcap.sv
`timescale 1ns/1ps
module bus_seq_rdcap #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DB_W-1:0] din,
    output logic            valid,
    output logic [DB_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= load;
            if (load) data <= din;
        end
    end
endmodule

// File: rtl/ext_bus_seq.sv
`timescale 1ns/1ps
module ext_bus_seq
    import ext_bus_seq_pkg::*;
#(
    parameter int CYC_LEN      = 15,
    parameter int ALE_LEN      = 4,
    parameter int HOLD_LEN     = 2,
    parameter int STB_LEN      = 6,
    parameter int DB_W         = 8,
    parameter int PC_W         = 12,
    parameter int INT_ROM_SIZE = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           req_op,
    input  logic [PC_W-1:0]      req_addr,
    input  logic [DB_W-1:0]      req_wdata,
    input  logic                 ext_access,
    input  logic [DB_W-1:0]      db_in,
    output logic                 ale,
    output logic                 psen_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic [DB_W-1:0]      db_out,
    output logic                 db_oe,
    output logic [PC_W-DB_W-1:0] p2_addr,
    output logic                 p2_oe,
    output logic                 rsp_valid,
    output logic [DB_W-1:0]      rsp_data
);
    localparam int PH_W    = $clog2(CYC_LEN);
    localparam int STB_BEG = ALE_LEN + HOLD_LEN;
    localparam logic [PH_W-1:0] PH_ALE_END  = PH_W'(ALE_LEN - 1);
    localparam logic [PH_W-1:0] PH_HOLD_END = PH_W'(STB_BEG - 1);
    localparam logic [PH_W-1:0] PH_STB_END  = PH_W'(STB_BEG + STB_LEN - 1);
    localparam logic [PC_W:0]   ROM_LIMIT   = (PC_W + 1)'(INT_ROM_SIZE);

    logic [PH_W-1:0] ph;
    logic            ph_last;
    bus_state_e      state, nxt;
    acc_kind_e       cur_kind, new_kind;
    logic [PC_W-1:0] cur_addr;
    logic [DB_W-1:0] cur_wdata;
    logic            cap_en;
    logic            lat_v;
    logic [DB_W-1:0] lat_q;
    logic            rd_load;
    logic            addr_phase;

    bus_seq_phase #(.CYC_LEN(CYC_LEN), .PH_W(PH_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph      (ph),
        .ph_last (ph_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_TAIL;
        else        state <= nxt;
    end

    // Transitions, each at a fixed clock of the machine cycle
    always_comb begin
        nxt = state;
        unique case (state)
            ST_ADDR:   if (ph == PH_ALE_END)  nxt = ST_HOLD;
            ST_HOLD:   if (ph == PH_HOLD_END) nxt = ST_STROBE;
            ST_STROBE: if (ph == PH_STB_END)  nxt = ST_TAIL;
            ST_TAIL:   if (ph_last)           nxt = ST_ADDR;
        endcase
    end

    assign cap_en = (state == ST_TAIL) && ph_last;

    // Request decode: internal fetches and idle/output cycles leave the bus alone
    always_comb begin
        new_kind = K_NONE;
        unique case (req_op)
            OP_FETCH: if (ext_access || ({1'b0, req_addr} >= ROM_LIMIT)) new_kind = K_FETCH;
            OP_READ:  new_kind = K_READ;
            OP_WRITE: new_kind = K_WRITE;
            default:  new_kind = K_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind  <= K_NONE;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else if (cap_en) begin
            cur_kind  <= new_kind;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
        end
    end

    bus_seq_outlatch #(.DB_W(DB_W)) u_outlatch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap_en && (req_op == OP_OUT)),
        .din   (req_wdata),
        .valid (lat_v),
        .q     (lat_q)
    );

    assign rd_load = (state == ST_STROBE) && (ph == PH_STB_END) &&
                     ((cur_kind == K_FETCH) || (cur_kind == K_READ));

    bus_seq_rdcap #(.DB_W(DB_W)) u_rdcap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_load),
        .din   (db_in),
        .valid (rsp_valid),
        .data  (rsp_data)
    );

    // Outputs from state and captured request
    always_comb begin
        addr_phase = (state == ST_ADDR) || (state == ST_HOLD);
        ale        = (state == ST_ADDR);
        psen_n     = 1'b1;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        db_oe      = lat_v;
        db_out     = lat_q;
        unique case (cur_kind)
            K_FETCH: begin
                psen_n = (state != ST_STROBE);
                db_oe  = addr_phase;
                db_out = cur_addr[DB_W-1:0];
            end
            K_READ: begin
                rd_n   = (state != ST_STROBE);
                db_oe  = addr_phase;
                db_out = cur_addr[DB_W-1:0];
            end
            K_WRITE: begin
                wr_n   = (state != ST_STROBE);
                db_oe  = 1'b1;
                db_out = addr_phase ? cur_addr[DB_W-1:0] : cur_wdata;
            end
            default: ;
        endcase
        p2_oe   = (cur_kind == K_FETCH);
        p2_addr = cur_addr[PC_W-1:DB_W];
    end
endmodule

// File: rtl/ext_bus_seq_chk.sv
`timescale 1ns/1ps
module ext_bus_seq_chk #(
    parameter int CYC_LEN = 15,
    parameter int DB_W    = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ale,
    input logic            psen_n,
    input logic            rd_n,
    input logic            wr_n,
    input logic            db_oe,
    input logic [DB_W-1:0] db_out,
    input logic            rsp_valid
);
    localparam int CW = $clog2(CYC_LEN) + 1;

    logic          ale_q;
    logic          seen;
    logic [CW-1:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q <= 1'b0;
            seen  <= 1'b0;
            gap   <= '0;
        end else begin
            ale_q <= ale;
            if (ale && !ale_q) begin
                seen <= 1'b1;
                gap  <= '0;
            end else if (gap != '1) begin
                gap <= gap + 1'b1;
            end
        end
    end

    AST_ALE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !ale_q && seen) |-> (gap == CW'(CYC_LEN - 1))); // R1

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1); // R9

    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !db_oe); // R9

    AST_NO_STROBE_IN_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n || !wr_n) |-> !ale); // R9

    AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> (db_oe && $stable(db_out))); // R6

    AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!psen_n || !rd_n)); // R7
endmodule

bind ext_bus_seq ext_bus_seq_chk #(.CYC_LEN(CYC_LEN), .DB_W(DB_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ale       (ale),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .db_oe     (db_oe),
    .db_out    (db_out),
    .rsp_valid (rsp_valid)
);

// File: tb/ext_bus_seq_tb.sv
`timescale 1ns/1ps
module ext_bus_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req_op = '0;
    logic [11:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ext_access = 1'b0;
    logic [7:0]  db_in = '0;
    logic        ale, psen_n, rd_n, wr_n, db_oe, p2_oe, rsp_valid;
    logic [7:0]  db_out, rsp_data;
    logic [3:0]  p2_addr;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   m_lat_v = 1'b0;
    logic [7:0] m_lat = '0;
    logic [31:0] seed_r;

    always #5 clk = ~clk;

    ext_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .ext_access(ext_access), .db_in(db_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .db_out(db_out), .db_oe(db_oe), .p2_addr(p2_addr), .p2_oe(p2_oe),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_ext_fetch(input logic [2:0] op, input logic [11:0] a, input logic ea);
        return (op == 3'd1) && (ea || (a >= 12'd1024));
    endfunction

    // One machine cycle; entered at the negedge just before the capture edge
    task automatic run_cycle(input logic [2:0] op, input logic [11:0] a,
                             input logic [7:0] wd, input logic ea, input logic [7:0] rdv);
        bit   xf, rdo, wro, exp_oe, exp_rv;
        logic [7:0] exp_db;
        string tag_db;
        req_op = op; req_addr = a; req_wdata = wd; ext_access = ea; db_in = rdv;
        xf  = is_ext_fetch(op, a, ea);
        rdo = (op == 3'd2);
        wro = (op == 3'd3);
        if (op == 3'd4) begin m_lat_v = 1'b1; m_lat = wd; end
        for (int ph = 0; ph < 15; ph++) begin
            @(posedge clk);
            @(negedge clk);
            if (ph == 0) begin
                // R2: later changes to the request must not matter
                req_op = 3'($urandom % 8); req_addr = 12'($urandom);
                req_wdata = 8'($urandom); ext_access = 1'($urandom);
            end
            chk("R1 ale", 16'(ale), 16'(ph < 4));
            chk((op == 3'd1 && !xf) ? "R4 psen_n" : "R3 psen_n", 16'(psen_n), 16'(!(xf && ph >= 6 && ph <= 11)));
            chk("R5 rd_n", 16'(rd_n), 16'(!(rdo && ph >= 6 && ph <= 11)));
            chk("R6 wr_n", 16'(wr_n), 16'(!(wro && ph >= 6 && ph <= 11)));
            if (xf || rdo) begin
                exp_oe = (ph < 6); exp_db = a[7:0]; tag_db = xf ? "R3 db" : "R5 db";
            end else if (wro) begin
                exp_oe = 1'b1; exp_db = (ph < 6) ? a[7:0] : wd; tag_db = "R6 db";
            end else begin
                exp_oe = m_lat_v; exp_db = m_lat; tag_db = (op == 3'd1) ? "R4 db" : "R8 db";
            end
            chk(tag_db, 16'(db_oe), 16'(exp_oe));
            if (exp_oe) chk(tag_db, 16'(db_out), 16'(exp_db));
            chk((op == 3'd1) ? "R4 p2_oe" : "R3 p2_oe", 16'(p2_oe), 16'(xf));
            if (xf) chk("R3 p2_addr", 16'(p2_addr), 16'(a[11:8]));
            exp_rv = (xf || rdo) && (ph == 12);
            chk("R7 rsp_valid", 16'(rsp_valid), 16'(exp_rv));
            if (exp_rv) chk("R7 rsp_data", 16'(rsp_data), 16'(rdv));
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        seed_r = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk("R1 reset ale", 16'(ale), 16'd0);
        chk("R9 reset strobes", 16'({psen_n, rd_n, wr_n}), 16'(3'b111));
        chk("R8 reset db_oe", 16'(db_oe), 16'd0);
        chk("R7 reset rsp_valid", 16'(rsp_valid), 16'd0);
        rst_n = 1'b1;
        // Directed corner cases
        run_cycle(3'd0, 12'h000, 8'h00, 1'b0, 8'h00);   // R8 no latch yet
        run_cycle(3'd1, 12'h3FF, 8'h00, 1'b1, 8'h3C);   // R4 forced external
        run_cycle(3'd1, 12'h3FF, 8'h00, 1'b0, 8'h3D);   // R4 internal, no bus
        run_cycle(3'd1, 12'h400, 8'h00, 1'b0, 8'hC3);   // R4 boundary, external
        run_cycle(3'd1, 12'hABC, 8'h00, 1'b0, 8'h5A);   // R3
        run_cycle(3'd2, 12'hF12, 8'h00, 1'b0, 8'h77);   // R5, R7
        run_cycle(3'd3, 12'h034, 8'h9E, 1'b1, 8'h00);   // R6
        run_cycle(3'd4, 12'h000, 8'hA5, 1'b0, 8'h00);   // R8 latch load
        run_cycle(3'd0, 12'h000, 8'h11, 1'b0, 8'h00);   // R8 held
        run_cycle(3'd1, 12'h800, 8'h00, 1'b0, 8'hE7);   // bus taken over
        run_cycle(3'd6, 12'h000, 8'h22, 1'b0, 8'h00);   // R10 unused code idle
        run_cycle(3'd1, 12'h010, 8'h33, 1'b0, 8'h00);   // R4 internal, latch shows
        // Constrained random mix
        for (int i = 0; i < 150; i++) begin
            run_cycle(3'($urandom % 8), 12'($urandom), 8'($urandom),
                      1'(($urandom % 4) == 0), 8'($urandom));
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        #1ms;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 act=hung exp=done");
            finish_run();
        end
    end
endmodule